// File: doc/BRIEF.md
# Masked Vector Expand/Compress Unit

This unit moves elements between a packed run and the lanes of a 16-lane vector, with a lane mask choosing which lanes take part. In expand mode the packed elements are spread out, one to each lane whose mask bit is set. In compress mode the selected lanes are gathered into consecutive low positions. For every operation a flag decides what happens to the lanes that receive no data. Those lanes either keep the value from an old destination vector (merge) or are cleared (zero).

Alongside the vector result, the unit reports how many packed elements the operation uses. It also gives an enable vector that marks exactly those packed positions. A memory interface beside it can use that vector to fetch or store only the needed elements, so an element past the mask population can never cause a fault. Operations enter through a valid/ready port. The result is registered and leaves through a valid/ready port one cycle later.

Top module: `vec_xc_unit`

## Requirements
- R1: In expand mode (op_mode = 0), packed source element k (bits k*EW upward of op_src) is written to the k-th lane whose mask bit is set, counting set bits from lane 0 upward. Mask bit i controls lane i.
- R2: In compress mode (op_mode = 1), the source lanes whose mask bit is set are written, in rising lane order, to result positions 0, 1, 2 and so on.
- R3: With op_zero = 0 (merge), every result lane that receives no element takes the op_old value of the same lane. These are the unselected lanes in expand mode and the positions at or above the population count in compress mode.
- R4: With op_zero = 1 (zero), those same result lanes are 0.
- R5: res_count equals the number of set bits in the accepted op_mask, and it never exceeds the lane count.
- R6: res_elem_en has exactly its low res_count bits set. Bit k marks packed element k as touched, and no other bit is set.
- R7: An all-zero mask gives res_count = 0 and res_elem_en = 0. The result is then op_old under merge, or all zeros under zero.
- R8: An operation accepted on a clock edge (op_valid and op_ready both high) appears with res_valid high after that same edge.
- R9: While res_valid is high and res_ready is low, op_ready is low, and res_data, res_count and res_elem_en hold their values.
- R10: After reset, res_valid is 0 and op_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation can be taken |
| op_mode | input | 1 | 0 = expand, 1 = compress |
| op_zero | input | 1 | 0 = merge lanes that get no data, 1 = clear them |
| op_mask | input | LANES | Lane select mask, bit i for lane i |
| op_src | input | LANES*EW | Source vector (packed run in expand, lanes in compress) |
| op_old | input | LANES*EW | Old destination vector used for merge |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result taken |
| res_data | output | LANES*EW | Result vector |
| res_count | output | $clog2(LANES+1) | Packed elements used or produced |
| res_elem_en | output | LANES | Packed element enable (low res_count bits set) |

## Verification
The handshake assertions assume the consumer follows the valid/ready rules. They also assume that op_mask, op_mode and op_zero are meaningful whenever op_valid is high. The bench drives every input only on falling edges, and it changes the offered operation only when it is either accepted or not offered at all. Under backpressure it keeps op_valid asserted with a second operation. This shows that the held result stays untouched until res_ready returns.

// File: rtl/xc_pkg.sv
package xc_pkg;
  typedef enum logic {
    XC_EXPAND   = 1'b0,
    XC_COMPRESS = 1'b1
  } xc_mode_e;
endpackage

// File: rtl/xc_route.sv
module xc_route #(
  parameter int LANES = 16,
  parameter int EW    = 32,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  xc_pkg::xc_mode_e      mode,
  input  logic                  zero_fill,
  input  logic [LANES-1:0]      mask,
  input  logic [LANES*EW-1:0]   src,
  input  logic [LANES*EW-1:0]   old,
  output logic [LANES*EW-1:0]   data,
  output logic [CW-1:0]         count
);
  // number of set mask bits strictly below lane 'upto'
  function automatic logic [CW-1:0] ones_below(input logic [LANES-1:0] m, input int upto);
    logic [CW-1:0] c;
    c = '0;
    for (int j = 0; j < LANES; j++)
      if (j < upto && m[j]) c = c + 1'b1;
    return c;
  endfunction

  logic [CW-1:0] pre  [LANES];
  logic [EW-1:0] fill [LANES];
  logic [EW-1:0] exp_v [LANES];
  logic [EW-1:0] cmp_v [LANES];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      pre[i]  = ones_below(mask, i);
      fill[i] = zero_fill ? '0 : old[i*EW +: EW];
    end
    count = ones_below(mask, LANES);
  end

  // expand: selected lane i takes packed element pre[i]
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      exp_v[i] = fill[i];
      if (mask[i])
        for (int k = 0; k < LANES; k++)
          if (pre[i] == CW'(k)) exp_v[i] = src[k*EW +: EW];
    end
  end

  // compress: position j takes the selected lane whose prefix equals j
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      cmp_v[j] = fill[j];
      for (int i = 0; i < LANES; i++)
        if (mask[i] && pre[i] == CW'(j)) cmp_v[j] = src[i*EW +: EW];
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++)
      data[i*EW +: EW] = (mode == xc_pkg::XC_COMPRESS) ? cmp_v[i] : exp_v[i];
  end
endmodule

// File: rtl/xc_thermo.sv
module xc_thermo #(
  parameter int LANES = 16,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic [CW-1:0]    count,
  output logic [LANES-1:0] en
);
  always_comb begin
    for (int k = 0; k < LANES; k++)
      en[k] = (CW'(k) < count);
  end
endmodule

// File: rtl/xc_outreg.sv
module xc_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_bits,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_bits
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bits  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_bits  <= in_bits;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bits)); // R9
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9
endmodule

// File: rtl/vec_xc_unit.sv
module vec_xc_unit #(
  parameter int LANES = 16,
  parameter int EW    = 32,
  localparam int CW   = $clog2(LANES + 1),
  localparam int DW   = LANES * EW,
  localparam int PW   = DW + CW + LANES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic            op_mode,
  input  logic            op_zero,
  input  logic [LANES-1:0] op_mask,
  input  logic [DW-1:0]   op_src,
  input  logic [DW-1:0]   op_old,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [DW-1:0]   res_data,
  output logic [CW-1:0]   res_count,
  output logic [LANES-1:0] res_elem_en
);
  logic [DW-1:0]    rt_data;
  logic [CW-1:0]    rt_count;
  logic [LANES-1:0] rt_en;
  logic [PW-1:0]    pack_in, pack_out;
  logic             op_fire;

  xc_route #(.LANES(LANES), .EW(EW)) u_route (
    .mode      (xc_pkg::xc_mode_e'(op_mode)),
    .zero_fill (op_zero),
    .mask      (op_mask),
    .src       (op_src),
    .old       (op_old),
    .data      (rt_data),
    .count     (rt_count)
  );

  xc_thermo #(.LANES(LANES)) u_thermo (
    .count (rt_count),
    .en    (rt_en)
  );

  assign pack_in = {rt_data, rt_count, rt_en};

  xc_outreg #(.W(PW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (op_valid),
    .in_ready  (op_ready),
    .in_bits   (pack_in),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_bits  (pack_out)
  );

  assign {res_data, res_count, res_elem_en} = pack_out;
  assign op_fire = op_valid && op_ready;

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> int'(res_count) == $countones($past(op_mask))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> int'(res_count) <= LANES); // R5
  AST_EN_POP: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones(res_elem_en) == int'(res_count)); // R6
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire && op_mask == '0 |=> res_elem_en == '0); // R7
  AST_ZERO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire && op_mask == '0 && op_zero |=> res_data == '0); // R4
endmodule

// File: tb/vec_xc_unit_tb.sv
`timescale 1ns/1ps
module vec_xc_unit_tb;
  localparam int LANES = 16;
  localparam int EW    = 32;
  localparam int DW    = LANES * EW;
  localparam int CW    = $clog2(LANES + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, op_mode = 1'b0, op_zero = 1'b0, res_ready = 1'b1;
  logic [LANES-1:0] op_mask = '0;
  logic [DW-1:0] op_src = '0, op_old = '0;
  logic op_ready, res_valid;
  logic [DW-1:0] res_data;
  logic [CW-1:0] res_count;
  logic [LANES-1:0] res_elem_en;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vec_xc_unit #(.LANES(LANES), .EW(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_mode(op_mode), .op_zero(op_zero), .op_mask(op_mask), .op_src(op_src),
    .op_old(op_old), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_count(res_count), .res_elem_en(res_elem_en)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model: walk lanes keeping a running packed index
  function automatic logic [DW-1:0] model(input logic cmp, input logic zr,
      input logic [LANES-1:0] m, input logic [DW-1:0] s, input logic [DW-1:0] o);
    logic [DW-1:0] r;
    int k = 0;
    for (int i = 0; i < LANES; i++) r[i*EW +: EW] = zr ? '0 : o[i*EW +: EW];
    for (int i = 0; i < LANES; i++) begin
      if (m[i]) begin
        if (cmp) r[k*EW +: EW] = s[i*EW +: EW];
        else     r[i*EW +: EW] = s[k*EW +: EW];
        k++;
      end
    end
    return r;
  endfunction

  function automatic int pop(input logic [LANES-1:0] m);
    int c = 0;
    for (int i = 0; i < LANES; i++) c += m[i];
    return c;
  endfunction

  task automatic run_op(input string req, input logic cmp, input logic zr, input logic [LANES-1:0] m);
    int p;
    @(negedge clk);
    op_valid = 1'b1; op_mode = cmp; op_zero = zr; op_mask = m;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    p = pop(m);
    chk({req, " R8 valid"}, DW'(res_valid), DW'(1));
    chk(req, res_data, model(cmp, zr, m, op_src, op_old));
    chk({req, " R5 count"}, DW'(res_count), DW'(p));
    chk({req, " R6 elem_en"}, DW'(res_elem_en), DW'((32'd1 << p) - 1));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 res_valid", DW'(res_valid), DW'(0));
    chk("R10 op_ready", DW'(op_ready), DW'(1));
  endtask

  task automatic t_expand();
    run_op("R1 R3 expand merge", 1'b0, 1'b0, 16'h4DB1);
    run_op("R1 R4 expand zero", 1'b0, 1'b1, 16'h4DB1);
    run_op("R1 expand single top", 1'b0, 1'b1, 16'h8000);
    run_op("R1 expand full", 1'b0, 1'b0, 16'hFFFF);
  endtask

  task automatic t_compress();
    run_op("R2 R3 compress merge", 1'b1, 1'b0, 16'hA5C3);
    run_op("R2 R4 compress zero", 1'b1, 1'b1, 16'hA5C3);
    run_op("R2 compress single top", 1'b1, 1'b0, 16'h8000);
    run_op("R2 compress full", 1'b1, 1'b1, 16'hFFFF);
  endtask

  task automatic t_empty();
    run_op("R7 empty merge expand", 1'b0, 1'b0, 16'h0000);
    chk("R7 merge returns old", res_data, op_old);
    run_op("R7 empty zero compress", 1'b1, 1'b1, 16'h0000);
    chk("R7 zero returns zeros", res_data, '0);
  endtask

  task automatic t_stall();
    logic [DW-1:0] first;
    @(negedge clk);
    res_ready = 1'b0;
    op_valid = 1'b1; op_mode = 1'b0; op_zero = 1'b0; op_mask = 16'h00F0;
    @(posedge clk);
    @(negedge clk);
    first = model(1'b0, 1'b0, 16'h00F0, op_src, op_old);
    chk("R9 stalled result", res_data, first);
    chk("R9 op_ready low", DW'(op_ready), DW'(0));
    op_mode = 1'b1; op_zero = 1'b1; op_mask = 16'h0F0F;
    @(posedge clk);
    @(negedge clk);
    chk("R9 held data", res_data, first);
    chk("R9 held count", DW'(res_count), DW'(4));
    chk("R9 still valid", DW'(res_valid), DW'(1));
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R8 R9 next op after release", res_data, model(1'b1, 1'b1, 16'h0F0F, op_src, op_old));
    @(posedge clk);
    @(negedge clk);
    chk("R8 drained", DW'(res_valid), DW'(0));
  endtask

  initial begin
    for (int i = 0; i < LANES; i++) begin
      op_src[i*EW +: EW] = 32'hA000_0000 + 32'(i);
      op_old[i*EW +: EW] = 32'hB000_0000 + 32'(i * 3);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_expand();
    t_compress();
    t_empty();
    t_stall();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule